// File: doc/BRIEF.md
# Pipelined Waveform Charge Integrator

The block takes a continuous 40 MHz stream of 10-bit digitized samples from four wire channels and keeps each channel's recent history in a circular delay line. A level-1 trigger arrives a fixed latency after the beam crossing it belongs to. When it arrives, the block reaches back by that latency and reads a baseline sample taken just before the crossing. It then sums a fixed-length window of samples that starts at the crossing. The charge is the window sum minus the baseline times the window length.

All four channels integrate the same window in parallel. Charges below a programmable threshold are discarded. Each surviving charge is packed with its channel number and an event tag and goes through a fixed-priority arbiter into a show-ahead output FIFO. A per-channel hit pulse marks each stored word. A trigger that lands while a window is still being summed is dropped and sets a sticky overrun flag.

Top module: `charge_window_integrator`

## Requirements
- R1: While reset is held, `empty_o` is 1, `hit_o` is 0 and `ovf_o` is 0.
- R2: The sample presented at a clock edge is the one for that edge. A trigger accepted at edge t integrates the samples of edges t-128 through t-89 (40 samples). The baseline is the sample of edge t-129.
- R3: The charge is the window sum minus 40 times the baseline, held in 16 bits unsigned.
- R4: When the baseline term exceeds the window sum, the charge is 0.
- R5: A charge below `thresh_i`, sampled at edge t+40, produces no word and no hit. A charge equal to or above it is stored.
- R6: The output word is {channel[25:24], event tag[23:16], charge[15:0]}. The event tag counts accepted triggers since reset, modulo 256, starting at 0.
- R7: Results of the window accepted at edge t are latched at edge t+40. The surviving channels then enter the FIFO one per edge, in ascending channel order, from edge t+41, provided the FIFO is not full.
- R8: `hit_o[c]` is high for exactly the one cycle after channel c's word enters the FIFO. At most one bit is set at a time.
- R9: A trigger at edges t+1 through t+39 is ignored and sets `ovf_o`, which stays set until reset. A trigger at edge t+40 is accepted.
- R10: The FIFO holds 8 words. `dout_o` shows the oldest word whenever `empty_o` is 0, and `rd_i` removes it at the next edge. A channel whose word meets a full FIFO keeps it pending until space appears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock; one sample per channel per edge |
| rst_n | input | 1 | Active-low synchronous reset |
| samp_i | input | 40 | Four 10-bit samples; channel c at bits [10c+9:10c] |
| trig_i | input | 1 | Level-1 trigger, one cycle per event |
| thresh_i | input | 16 | Zero-suppression threshold |
| rd_i | input | 1 | Pop the oldest FIFO word |
| dout_o | output | 26 | Oldest FIFO word |
| empty_o | output | 1 | FIFO holds no word |
| hit_o | output | 4 | Per-channel stored-word pulse |
| ovf_o | output | 1 | Sticky flag: a trigger arrived during a window |

## Verification
A misaligned delay-line tap or a wrong baseline index shows up as a wrong charge in the first word read after the first trigger, 41 cycles after that trigger. A stuck window counter or busy flag shows up within one window length, either as a spurious overrun or as a missing or mistimed block of words. Arbiter or pending-state faults appear within four cycles of a result, as a wrong channel order, a wrong hit bit or lost words once the FIFO is held full.

// File: rtl/cwi_pkg.sv
package cwi_pkg;

  // Window charge after baseline removal, clamped at zero.
  function automatic logic [31:0] net_charge(input logic [31:0] sum,
                                              input logic [31:0] base,
                                              input logic [31:0] win_len);
    logic [31:0] base_total;
    base_total = base * win_len;
    return (sum >= base_total) ? (sum - base_total) : 32'd0;
  endfunction

endpackage

// File: rtl/cwi_delay.sv
module cwi_delay #(
  parameter int SAMP_W = 10,
  parameter int AW     = 8
) (
  input  logic              clk,
  input  logic [AW-1:0]     wr_ptr,
  input  logic [AW-1:0]     tap_ptr,
  input  logic [AW-1:0]     base_ptr,
  input  logic [SAMP_W-1:0] din,
  output logic [SAMP_W-1:0] tap_o,
  output logic [SAMP_W-1:0] base_o
);
  localparam int DEPTH = 1 << AW;

  logic [SAMP_W-1:0] hist [DEPTH];

  always_ff @(posedge clk) begin
    hist[wr_ptr] <= din;
  end

  assign tap_o  = hist[tap_ptr];
  assign base_o = hist[base_ptr];
endmodule

// File: rtl/cwi_seq.sv
module cwi_seq #(
  parameter int LAT   = 128,
  parameter int WIN   = 40,
  parameter int AW    = 8,
  parameter int TAG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_i,
  output logic [AW-1:0]    wr_ptr,
  output logic [AW-1:0]    tap_ptr,
  output logic [AW-1:0]    base_ptr,
  output logic             accept_o,
  output logic             reject_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [TAG_W-1:0] tag_o,
  output logic             ovf_o
);
  localparam int CW = $clog2(WIN + 1);
  localparam logic [AW-1:0] LAT_OFS  = AW'(LAT);
  localparam logic [AW-1:0] BASE_OFS = AW'(LAT + 1);
  localparam logic [CW-1:0] LAST     = CW'(WIN - 1);

  logic [CW-1:0]    cnt;
  logic [TAG_W-1:0] tcount;

  assign accept_o = trig_i & ~busy_o;
  assign reject_o = trig_i & busy_o;
  assign tap_ptr  = wr_ptr - LAT_OFS;
  assign base_ptr = wr_ptr - BASE_OFS;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      busy_o <= 1'b0;
      done_o <= 1'b0;
      cnt    <= '0;
      tcount <= '0;
      tag_o  <= '0;
      ovf_o  <= 1'b0;
    end else begin
      wr_ptr <= wr_ptr + 1'b1;
      done_o <= 1'b0;
      if (accept_o) begin
        busy_o <= 1'b1;
        cnt    <= CW'(1);
        tag_o  <= tcount;
        tcount <= tcount + 1'b1;
      end else if (busy_o) begin
        cnt <= cnt + 1'b1;
        if (cnt == LAST) begin
          busy_o <= 1'b0;
          done_o <= 1'b1;
        end
      end
      if (reject_o) ovf_o <= 1'b1;
    end
  end
endmodule

// File: rtl/cwi_chan.sv
module cwi_chan #(
  parameter int SAMP_W = 10,
  parameter int ACC_W  = 16,
  parameter int TAG_W  = 8,
  parameter int WIN    = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              busy_i,
  input  logic              done_i,
  input  logic [SAMP_W-1:0] tap_i,
  input  logic [SAMP_W-1:0] base_i,
  input  logic [ACC_W-1:0]  thresh_i,
  input  logic [TAG_W-1:0]  tag_i,
  input  logic              grant_i,
  output logic              keep_o,
  output logic              pend_o,
  output logic [ACC_W-1:0]  charge_o,
  output logic [TAG_W-1:0]  tag_o
);
  import cwi_pkg::*;

  logic [ACC_W-1:0]  acc;
  logic [SAMP_W-1:0] base_r;
  logic [ACC_W-1:0]  charge;
  logic [ACC_W-1:0]  tap_ext;

  assign tap_ext = {{(ACC_W-SAMP_W){1'b0}}, tap_i};
  assign charge  = ACC_W'(net_charge(32'(acc), 32'(base_r), 32'(WIN)));
  assign keep_o  = done_i & (charge >= thresh_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc      <= '0;
      base_r   <= '0;
      pend_o   <= 1'b0;
      charge_o <= '0;
      tag_o    <= '0;
    end else begin
      if (start_i) begin
        acc    <= tap_ext;
        base_r <= base_i;
      end else if (busy_i) begin
        acc <= acc + tap_ext;
      end
      if (keep_o) begin
        pend_o   <= 1'b1;
        charge_o <= charge;
        tag_o    <= tag_i;
      end else if (grant_i) begin
        pend_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/cwi_outq.sv
module cwi_outq #(
  parameter int NCH    = 4,
  parameter int OUT_W  = 26,
  parameter int FDEPTH = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NCH-1:0]       pend_i,
  input  logic [NCH*OUT_W-1:0] words_i,
  input  logic                 rd_i,
  output logic [NCH-1:0]       grant_o,
  output logic                 push_o,
  output logic [OUT_W-1:0]     dout_o,
  output logic                 empty_o,
  output logic [NCH-1:0]       hit_o
);
  localparam int PW = $clog2(FDEPTH);
  localparam int CW = $clog2(FDEPTH + 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(FDEPTH);

  logic [OUT_W-1:0] store [FDEPTH];
  logic [PW-1:0]    wp, rp;
  logic [CW-1:0]    cnt;
  logic             full, pop;
  logic [OUT_W-1:0] wsel;

  assign full    = (cnt == FULL_CNT);
  assign empty_o = (cnt == '0);
  assign pop     = rd_i & ~empty_o;
  assign push_o  = |grant_o;
  assign dout_o  = store[rp];

  always_comb begin
    logic found;
    found   = 1'b0;
    grant_o = '0;
    wsel    = '0;
    for (int i = 0; i < NCH; i++) begin
      if (pend_i[i] && !found && !full) begin
        grant_o[i] = 1'b1;
        wsel       = words_i[i*OUT_W +: OUT_W];
        found      = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push_o) store[wp] <= wsel;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      cnt   <= '0;
      hit_o <= '0;
    end else begin
      hit_o <= grant_o;
      if (push_o) wp <= wp + 1'b1;
      if (pop)    rp <= rp + 1'b1;
      if (push_o && !pop)      cnt <= cnt + 1'b1;
      else if (pop && !push_o) cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/charge_window_integrator.sv
module charge_window_integrator #(
  parameter int NCH    = 4,
  parameter int SAMP_W = 10,
  parameter int LAT    = 128,
  parameter int WIN    = 40,
  parameter int ACC_W  = 16,
  parameter int TAG_W  = 8,
  parameter int FDEPTH = 8,
  localparam int CH_W  = $clog2(NCH),
  localparam int OUT_W = CH_W + TAG_W + ACC_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NCH*SAMP_W-1:0] samp_i,
  input  logic                  trig_i,
  input  logic [ACC_W-1:0]      thresh_i,
  input  logic                  rd_i,
  output logic [OUT_W-1:0]      dout_o,
  output logic                  empty_o,
  output logic [NCH-1:0]        hit_o,
  output logic                  ovf_o
);
  localparam int AW = $clog2(LAT + 2);

  logic [AW-1:0]        wr_ptr, tap_ptr, base_ptr;
  logic                 trig_accept, trig_reject, win_busy, win_done;
  logic [TAG_W-1:0]     win_tag;
  logic [NCH-1:0]       ch_keep, ch_pend, ch_grant;
  logic                 q_push;
  logic [NCH*OUT_W-1:0] ch_words;

  cwi_seq #(.LAT(LAT), .WIN(WIN), .AW(AW), .TAG_W(TAG_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .trig_i(trig_i),
    .wr_ptr(wr_ptr), .tap_ptr(tap_ptr), .base_ptr(base_ptr),
    .accept_o(trig_accept), .reject_o(trig_reject),
    .busy_o(win_busy), .done_o(win_done), .tag_o(win_tag), .ovf_o(ovf_o)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [SAMP_W-1:0] tap, base;
    logic [ACC_W-1:0]  charge;
    logic [TAG_W-1:0]  tag;

    cwi_delay #(.SAMP_W(SAMP_W), .AW(AW)) u_dly (
      .clk(clk), .wr_ptr(wr_ptr), .tap_ptr(tap_ptr), .base_ptr(base_ptr),
      .din(samp_i[c*SAMP_W +: SAMP_W]), .tap_o(tap), .base_o(base)
    );

    cwi_chan #(.SAMP_W(SAMP_W), .ACC_W(ACC_W), .TAG_W(TAG_W), .WIN(WIN)) u_int (
      .clk(clk), .rst_n(rst_n), .start_i(trig_accept), .busy_i(win_busy),
      .done_i(win_done), .tap_i(tap), .base_i(base), .thresh_i(thresh_i),
      .tag_i(win_tag), .grant_i(ch_grant[c]), .keep_o(ch_keep[c]),
      .pend_o(ch_pend[c]), .charge_o(charge), .tag_o(tag)
    );

    assign ch_words[c*OUT_W +: OUT_W] = {CH_W'(c), tag, charge};
  end

  cwi_outq #(.NCH(NCH), .OUT_W(OUT_W), .FDEPTH(FDEPTH)) u_q (
    .clk(clk), .rst_n(rst_n), .pend_i(ch_pend), .words_i(ch_words),
    .rd_i(rd_i), .grant_o(ch_grant), .push_o(q_push), .dout_o(dout_o),
    .empty_o(empty_o), .hit_o(hit_o)
  );
endmodule

// File: rtl/cwi_checker.sv
module cwi_checker #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           trig_i,
  input logic           empty_o,
  input logic [NCH-1:0] hit_o,
  input logic           ovf_o,
  input logic           trig_accept,
  input logic           trig_reject,
  input logic           win_busy,
  input logic           win_done,
  input logic [NCH-1:0] ch_pend,
  input logic [NCH-1:0] ch_grant,
  input logic           q_push
);
  p_reset_state_r1: assert property (@(posedge clk)
    !rst_n |=> (!rst_n |-> (empty_o && hit_o == '0 && !ovf_o)));

  p_window_closes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(win_busy) |-> win_done);

  p_no_accept_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_i && win_busy) |-> !trig_accept);

  p_reject_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
    trig_reject |=> ovf_o);

  p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |=> ovf_o);

  p_grant_lowest_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_grant) && ((ch_grant & ~ch_pend) == '0)
    && (((ch_grant - 1'b1) & ch_pend & {NCH{q_push}}) == '0));

  p_hit_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_o));

  p_hit_after_push_r8: assert property (@(posedge clk) disable iff (!rst_n)
    q_push |=> (hit_o != '0 && !empty_o));

  p_pend_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(ch_pend) & ~$past(ch_grant) & ~ch_pend) == '0));
endmodule

bind charge_window_integrator cwi_checker u_chk (.*);

// File: tb/charge_window_integrator_test.sv
module charge_window_integrator_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [39:0] samp_i = '0;
  logic        trig_i = 1'b0;
  logic [15:0] thresh_i = '0;
  logic        rd_i = 1'b0;
  logic [25:0] dout_o;
  logic        empty_o;
  logic [3:0]  hit_o;
  logic        ovf_o;

  charge_window_integrator uut (
    .clk(clk), .rst_n(rst_n), .samp_i(samp_i), .trig_i(trig_i),
    .thresh_i(thresh_i), .rd_i(rd_i), .dout_o(dout_o), .empty_o(empty_o),
    .hit_o(hit_o), .ovf_o(ovf_o)
  );

  always #4 clk = ~clk;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  // reference model state
  int          hist [4][3000];
  int          n_edge = 0;
  bit          m_busy = 0;
  int          m_start = 0;
  int          m_tag = 0;
  int          m_tcnt = 0;
  bit          m_ovf = 0;
  bit          m_pend [4];
  logic [25:0] m_word [4];
  logic [25:0] m_q [$];
  logic [3:0]  m_hit = '0;

  function automatic int gen(int c, int n);
    int v;
    if (n >= 450 && n < 560) begin
      v = 50;
      if (c == 1 && n >= 480 && n < 490) v += 30;
      if (c == 2 && n == 480) v += 100;
      if (c == 3 && n == 480) v += 99;
    end else if (n >= 650 && n < 760) begin
      v = (n == 671) ? 900 : 100;
    end else if (n < 420) begin
      v = (n * 7 + c * 13) % 1024;
    end else begin
      v = (n * 29 + c * 211 + (n * n) % 97) % 1024;
    end
    return v;
  endfunction

  function automatic bit trig_at(int n);
    if (n == 300 || n == 400 || n == 600 || n == 800) return 1;
    if (n == 1000 || n == 1005 || n == 1040 || n == 1079) return 1;
    if (n == 1200 || n == 1250 || n == 1300) return 1;
    if (n >= 1500 && n < 2400 && (n - 1500) % 41 == 0) return 1;
    return 0;
  endfunction

  function automatic bit rd_at(int n);
    if (n >= 1180 && n < 1420) return 0;
    if (n >= 1500) return (n % 3) != 0;
    return 1;
  endfunction

  function automatic int thr_at(int n);
    if (n >= 550 && n < 700) return 100;
    if (n >= 1600 && n < 1800) return 20000;
    return 0;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at edge %0d: actual 0x%0h expected 0x%0h", req, n_edge, act, exp);
    end
  endtask

  // behavioural reference, one step per active clock edge
  always @(posedge clk) begin
    if (rst_n) begin
      int n, pre, g, sum, base, q;
      n = n_edge;
      for (int c = 0; c < 4; c++) hist[c][n] = int'(samp_i[c*10 +: 10]);
      pre = m_q.size();
      if (rd_i && pre > 0) void'(m_q.pop_front());
      m_hit = '0;
      g = -1;
      if (pre < 8) begin
        for (int c = 3; c >= 0; c--) if (m_pend[c]) g = c;
      end
      if (g >= 0) begin
        m_q.push_back(m_word[g]);
        m_pend[g] = 0;
        m_hit[g] = 1'b1;
      end
      if (m_busy && n == m_start + 40) begin
        for (int c = 0; c < 4; c++) begin
          sum = 0;
          for (int k = 0; k < 40; k++) sum += hist[c][m_start - 128 + k];
          base = hist[c][m_start - 129];
          q = sum - 40 * base;
          if (q < 0) q = 0;
          if (q >= int'(thresh_i)) begin
            m_pend[c] = 1;
            m_word[c] = {2'(c), 8'(m_tag), 16'(q)};
          end
        end
        m_busy = 0;
      end
      if (trig_i) begin
        if (m_busy) m_ovf = 1;
        else begin
          m_busy  = 1;
          m_start = n;
          m_tag   = m_tcnt;
          m_tcnt  = (m_tcnt + 1) % 256;
        end
      end
      n_edge = n + 1;
    end
  end

  task automatic drive(int n);
    for (int c = 0; c < 4; c++) samp_i[c*10 +: 10] = 10'(gen(c, n));
    trig_i   = trig_at(n);
    rd_i     = rd_at(n);
    thresh_i = 16'(thr_at(n));
  endtask

  initial begin
    logic [3:0] hits_seen;
    hits_seen = '0;
    for (int c = 0; c < 4; c++) m_pend[c] = 0;
    repeat (4) @(negedge clk);
    // R1: reset state
    check(empty_o === 1'b1, "R1 empty", int'(empty_o), 1);
    check(hit_o === 4'b0, "R1 hit", int'(hit_o), 0);
    check(ovf_o === 1'b0, "R1 ovf", int'(ovf_o), 0);
    drive(0);
    rst_n = 1'b1;
    while (n_edge < 2600) begin
      @(negedge clk);
      check(empty_o === (m_q.size() == 0), "R10 empty", int'(empty_o), int'(m_q.size() == 0));
      if (m_q.size() > 0)
        check(dout_o === m_q[0], "R2 R3 R4 R6 R7 word", int'(dout_o), int'(m_q[0]));
      check(hit_o === m_hit, "R8 hit", int'(hit_o), int'(m_hit));
      check(ovf_o === m_ovf, "R9 ovf", int'(ovf_o), int'(m_ovf));
      if (n_edge > 640 && n_edge <= 660) hits_seen |= hit_o;
      // R5: only channels 1 (charge 300) and 2 (charge 100 = threshold) survive
      if (n_edge == 660) check(hits_seen == 4'b0110, "R5 survivors", int'(hits_seen), 6);
      // R9: still clear before the first overlapping trigger
      if (n_edge == 1004) check(ovf_o === 1'b0, "R9 ovf clear", int'(ovf_o), 0);
      drive(n_edge);
    end
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(64'd8 * 64'd200000);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule